// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. Each cycle it takes the accumulator value, one operand value and an operation code. The operand may come from a register, from memory or from an immediate byte. The block returns a result, a strobe that says whether the result goes back to the accumulator, and a second strobe for operations whose result goes back to the operand's own location (single-register increment and decrement). The result and both strobes are combinational.

Five status flags are held in a register inside the block: sign, zero, auxiliary carry, parity and carry. They update on the rising clock edge of every cycle in which an operation is valid. Each operation class updates only its own subset of the flags. The carry used by add-with-carry, subtract-with-borrow and the rotates through carry is the stored carry flag.

Operation codes on `op_i`: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 rotate left circular, 9 rotate right circular, 10 rotate left through carry, 11 rotate right through carry, 12 complement accumulator, 13 complement carry, 14 set carry, 15 increment operand, 16 decrement operand. Codes 17 to 31 are unassigned.

Top module: `acc_alu`

## Requirements
- R1: Add (code 0) gives result (A+B) mod 256 and add with carry (code 1) gives (A+B+CY) mod 256. CY (flags_o bit 0) becomes 1 when the 9-bit sum is 256 or more. acc_we_o is high.
- R2: Subtract (code 2) gives (A−B) mod 256 and subtract with borrow (code 3) gives (A−B−CY) mod 256. CY becomes 1 when B plus the borrow-in exceeds A. acc_we_o is high.
- R3: Compare (code 4) sets all five flags exactly as subtract does, and keeps acc_we_o low.
- R4: AND, OR and XOR (codes 5 to 7) give the bitwise result with acc_we_o high, and they clear both CY and AC (flags_o bit 2).
- R5: Rotate left circular (code 8) gives {A[6:0],A[7]} and sets CY to A[7]. Rotate right circular (code 9) gives {A[0],A[7:1]} and sets CY to A[0].
- R6: Rotate left through carry (code 10) gives {A[6:0],CY} and sets CY to A[7]. Rotate right through carry (code 11) gives {CY,A[7:1]} and sets CY to A[0].
- R7: The four rotates leave S (bit 4), Z (bit 3), AC (bit 2) and P (bit 1) unchanged.
- R8: Complement accumulator (code 12) gives ~A with acc_we_o high and leaves all flags unchanged.
- R9: Complement carry (code 13) inverts CY and set carry (code 14) forces CY to 1. Both keep acc_we_o and opnd_we_o low and leave the other flags unchanged.
- R10: For every operation that updates them, S is set to result bit 7, Z is set when the 8-bit result is 0, and P is set when the result has an even number of ones.
- R11: AC is set on a carry out of bit 3 for addition and increment, and on a borrow into bit 4 for subtraction, compare and decrement.
- R12: Increment (code 15) and decrement (code 16) give B+1 and B−1 modulo 256, with opnd_we_o high and acc_we_o low. They update S, Z, P and AC and leave CY unchanged.
- R13: When op_valid_i is low, or when the code is unassigned, both strobes are low and the flags hold.
- R14: While rst_ni is low, all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| acc_i | input | DW | Accumulator value |
| opnd_i | input | DW | Operand value |
| result_o | output | DW | Operation result |
| acc_we_o | output | 1 | Write result to accumulator |
| opnd_we_o | output | 1 | Write result to operand location |
| flags_o | output | 5 | Stored flags {S,Z,AC,P,CY} |

## Verification
The assertions assume that op_valid_i, op_i and the data inputs are settled at every rising edge after reset, and that unassigned codes may appear. They make no assumption about operand values. The bench changes every input only on the falling edge. It draws codes from the full assigned range plus two unassigned ones, and it deasserts op_valid_i at random. This means each assertion sees both its trigger and its idle case.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned NFLAG = 5;
  localparam int unsigned FL_CY = 0;
  localparam int unsigned FL_P  = 1;
  localparam int unsigned FL_AC = 2;
  localparam int unsigned FL_Z  = 3;
  localparam int unsigned FL_S  = 4;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_RLC = 5'd8,  OP_RRC = 5'd9,  OP_RAL = 5'd10, OP_RAR = 5'd11,
    OP_CMA = 5'd12, OP_CMC = 5'd13, OP_STC = 5'd14, OP_INR = 5'd15,
    OP_DCR = 5'd16
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         half_o
);
  logic [W:0] full;
  logic [4:0] lo;

  // on subtract, cin_i is a borrow and cout_o is the borrow out
  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      lo   = {1'b0, a_i[3:0]} - {1'b0, b_i[3:0]} - {4'b0, cin_i};
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      lo   = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]} + {4'b0, cin_i};
    end
  end

  assign res_o  = full[W-1:0];
  assign cout_o = full[W];
  assign half_o = lo[4];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_RLC: begin res_o = {a_i[W-2:0], a_i[W-1]}; cy_o = a_i[W-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[W-1:1]};   cy_o = a_i[0];   end
      OP_RAL: begin res_o = {a_i[W-2:0], cy_i};     cy_o = a_i[W-1]; end
      OP_RAR: begin res_o = {cy_i, a_i[W-1:1]};     cy_o = a_i[0];   end
      OP_CMA: res_o = ~a_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int unsigned NF = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] upd_i,
  input  logic [NF-1:0] nxt_i,
  output logic [NF-1:0] q_o
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[i] <= 1'b0;
      else if (upd_i[i]) q_o[i] <= nxt_i[i];
    end
  end

  p_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i == '0) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  output logic [DW-1:0] result_o,
  output logic          acc_we_o,
  output logic          opnd_we_o,
  output logic [NFLAG-1:0] flags_o
);
  localparam logic [NFLAG-1:0] ALL_FL = '1;
  localparam logic [NFLAG-1:0] CY_FL  = NFLAG'(1) << FL_CY;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic is_arith, is_cmp, is_sub, use_cy, is_incdec, is_dec;
  logic is_logic, is_rot, is_cma, is_cmc, is_stc;

  always_comb begin
    is_arith = 1'b0; is_cmp = 1'b0; is_sub = 1'b0; use_cy = 1'b0;
    is_incdec = 1'b0; is_dec = 1'b0; is_logic = 1'b0; is_rot = 1'b0;
    is_cma = 1'b0; is_cmc = 1'b0; is_stc = 1'b0;
    case (op)
      OP_ADD: is_arith = 1'b1;
      OP_ADC: begin is_arith = 1'b1; use_cy = 1'b1; end
      OP_SUB: begin is_arith = 1'b1; is_sub = 1'b1; end
      OP_SBB: begin is_arith = 1'b1; is_sub = 1'b1; use_cy = 1'b1; end
      OP_CMP: begin is_arith = 1'b1; is_sub = 1'b1; is_cmp = 1'b1; end
      OP_AND, OP_OR, OP_XOR: is_logic = 1'b1;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: is_rot = 1'b1;
      OP_CMA: is_cma = 1'b1;
      OP_CMC: is_cmc = 1'b1;
      OP_STC: is_stc = 1'b1;
      OP_INR: is_incdec = 1'b1;
      OP_DCR: begin is_incdec = 1'b1; is_dec = 1'b1; end
      default: ;
    endcase
  end

  logic [DW-1:0] as_a, as_b, as_res, lg_res, res;
  logic          as_cin, as_cout, as_half, lg_cy, cy_q;

  assign cy_q   = flags_o[FL_CY];
  assign as_a   = is_incdec ? opnd_i : acc_i;
  assign as_b   = is_incdec ? '0 : opnd_i;
  assign as_cin = use_cy ? cy_q : is_incdec;

  alu_addsub #(.W(DW)) u_addsub (
    .a_i(as_a), .b_i(as_b), .cin_i(as_cin), .sub_i(is_sub | is_dec),
    .res_o(as_res), .cout_o(as_cout), .half_o(as_half)
  );

  alu_logic #(.W(DW)) u_logic (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .cy_i(cy_q),
    .res_o(lg_res), .cy_o(lg_cy)
  );

  assign res = (is_arith | is_incdec) ? as_res : lg_res;

  logic [NFLAG-1:0] fl_nxt, fl_upd, upd_raw;

  always_comb begin
    fl_nxt[FL_S]  = res[DW-1];
    fl_nxt[FL_Z]  = (res == '0);
    fl_nxt[FL_P]  = ~^res;
    fl_nxt[FL_AC] = (is_arith | is_incdec) & as_half;
    if (is_arith)      fl_nxt[FL_CY] = as_cout;
    else if (is_rot)   fl_nxt[FL_CY] = lg_cy;
    else if (is_cmc)   fl_nxt[FL_CY] = ~cy_q;
    else if (is_stc)   fl_nxt[FL_CY] = 1'b1;
    else               fl_nxt[FL_CY] = 1'b0;

    if (is_arith | is_logic)          upd_raw = ALL_FL;
    else if (is_incdec)               upd_raw = ALL_FL & ~CY_FL;
    else if (is_rot | is_cmc | is_stc) upd_raw = CY_FL;
    else                              upd_raw = '0;
  end

  assign fl_upd = op_valid_i ? upd_raw : '0;

  alu_flag_reg #(.NF(NFLAG)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(fl_upd), .nxt_i(fl_nxt), .q_o(flags_o)
  );

  assign result_o  = res;
  assign acc_we_o  = op_valid_i & ((is_arith & ~is_cmp) | is_logic | is_rot | is_cma);
  assign opnd_we_o = op_valid_i & is_incdec;

  p_cmp_nowr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 5'd4) |-> !acc_we_o);
  p_logic_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i >= 5'd5 && op_i <= 5'd7) |=> (!flags_o[FL_CY] && !flags_o[FL_AC]));
  p_rot_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i >= 5'd8 && op_i <= 5'd11) |=> (flags_o[4:1] == $past(flags_o[4:1])));
  p_cma_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 5'd12) |=> $stable(flags_o));
  p_stc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 5'd14) |=> flags_o[FL_CY]);
  p_cmc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 5'd13) |=> (flags_o[FL_CY] != $past(flags_o[FL_CY])));
  p_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 5'd0) |=> (flags_o[FL_Z] == ($past(result_o) == '0)));
  p_incdec_cy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_i == 5'd15 || op_i == 5'd16)) |=> $stable(flags_o[FL_CY]));
  p_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> (!acc_we_o && !opnd_we_o));
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  localparam time TCK = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc = '0, opnd = '0;
  logic [7:0] res;
  logic       awe, owe;
  logic [4:0] fl;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [4:0] mfl = '0;

  always #(TCK/2) clk = ~clk;

  acc_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(vld), .op_i(op),
    .acc_i(acc), .opnd_i(opnd), .result_o(res), .acc_we_o(awe),
    .opnd_we_o(owe), .flags_o(fl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s op=%0d a=%02h b=%02h actual=%0h expected=%0h", tag, op, acc, opnd, act, exp);
    end
  endtask

  function automatic string tag_of(input int o);
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      4: return "R3";
      5, 6, 7: return "R4";
      8, 9: return "R5";
      10, 11: return "R6";
      12: return "R8";
      13, 14: return "R9";
      15, 16: return "R12";
      default: return "R13";
    endcase
  endfunction

  // returns {res[7:0], acc_we, opnd_we, flags[4:0]}
  function automatic logic [14:0] model(input int o, input int a, input int b, input logic [4:0] f);
    int t, cy, r, ac;
    logic [4:0] nf;
    logic aw, ow;
    logic [7:0] rb;
    cy = f[0]; nf = f; aw = 0; ow = 0; r = a; ac = 0;
    case (o)
      0, 1: begin
        t = a + b + ((o == 1) ? cy : 0);
        ac = ((a % 16) + (b % 16) + ((o == 1) ? cy : 0)) > 15;
        r = t % 256; nf[0] = t > 255; aw = 1;
      end
      2, 3, 4: begin
        t = b + ((o == 3) ? cy : 0);
        ac = (a % 16) < ((b % 16) + ((o == 3) ? cy : 0));
        r = (a - t + 512) % 256; nf[0] = t > a; aw = (o != 4);
      end
      5: begin r = a & b; aw = 1; nf[0] = 0; end
      6: begin r = a | b; aw = 1; nf[0] = 0; end
      7: begin r = a ^ b; aw = 1; nf[0] = 0; end
      8:  begin r = ((a * 2) % 256) + (a / 128); nf[0] = a / 128; aw = 1; end
      9:  begin r = (a / 2) + (a % 2) * 128; nf[0] = a % 2; aw = 1; end
      10: begin r = ((a * 2) % 256) + cy; nf[0] = a / 128; aw = 1; end
      11: begin r = (a / 2) + cy * 128; nf[0] = a % 2; aw = 1; end
      12: begin r = 255 - a; aw = 1; end
      13: nf[0] = !cy;
      14: nf[0] = 1;
      15: begin r = (b + 1) % 256; ac = (b % 16) == 15; ow = 1; end
      16: begin r = (b + 255) % 256; ac = (b % 16) == 0; ow = 1; end
      default: ;
    endcase
    rb = r[7:0];
    if (o <= 7 || o == 15 || o == 16) begin
      nf[4] = rb[7];
      nf[3] = (r == 0);
      nf[1] = ~^rb;
      nf[2] = (o <= 4 || o >= 15) ? ac[0] : 1'b0;
    end
    return {rb, aw, ow, nf};
  endfunction

  task automatic run_op(input bit v, input int o, input int a, input int b);
    logic [14:0] e;
    string tg;
    @(negedge clk);
    vld = v; op = o[4:0]; acc = a[7:0]; opnd = b[7:0];
    e = model(o, a, b, mfl);
    tg = v ? tag_of(o) : "R13";
    #2;
    chk(awe == (v & e[6]), tg, awe, v & e[6]);
    chk(owe == (v & e[5]), tg, owe, v & e[5]);
    if (v && (e[6] || e[5])) chk(res == e[14:7], tg, res, e[14:7]);
    if (v) mfl = e[4:0];
    @(posedge clk); #1;
    chk(fl[0] == mfl[0], tg, fl[0], mfl[0]);
    chk({fl[4], fl[3], fl[1]} == {mfl[4], mfl[3], mfl[1]},
        (v && o >= 8 && o <= 11) ? "R7" : (v && o <= 16 ? "R10" : "R13"),
        {fl[4], fl[3], fl[1]}, {mfl[4], mfl[3], mfl[1]});
    chk(fl[2] == mfl[2],
        (v && o >= 8 && o <= 11) ? "R7" : (v && o <= 16 ? "R11" : "R13"), fl[2], mfl[2]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #(TCK * 3);
    chk(fl == 5'b0, "R14", fl, 0);
    rst_n = 1'b1;
    // directed corners
    run_op(1, 0, 8'hFF, 8'h01);   // wrap to zero: Z, CY, AC
    run_op(1, 1, 8'h7F, 8'h00);   // carry in crosses sign
    run_op(1, 2, 8'h00, 8'h01);   // borrow
    run_op(1, 3, 8'h10, 8'hFF);   // borrow in with 0xFF operand
    run_op(1, 4, 8'h42, 8'h42);   // equal compare
    run_op(1, 4, 8'h05, 8'h80);
    run_op(1, 14, 0, 0);
    run_op(1, 10, 8'h01, 0);      // carry enters bit 0
    run_op(1, 11, 8'h80, 0);
    run_op(1, 13, 0, 0);
    run_op(1, 8, 8'h81, 0);
    run_op(1, 9, 8'h01, 0);
    run_op(1, 15, 0, 8'hFF);      // increment wraps, carry kept
    run_op(1, 16, 0, 8'h00);
    run_op(1, 16, 0, 8'h10);
    run_op(1, 12, 8'h5A, 0);
    run_op(1, 5, 8'hF0, 8'h0F);
    run_op(1, 14, 0, 0);
    run_op(1, 7, 8'hAA, 8'h55);
    run_op(0, 0, 8'hFF, 8'hFF);   // idle
    run_op(1, 20, 8'hFF, 8'h01);  // unassigned
    for (int i = 0; i < 4000; i++) begin
      run_op($urandom_range(0, 9) != 0, $urandom_range(0, 18),
             $urandom_range(0, 255), $urandom_range(0, 255));
    end
    // reset mid-run clears flags
    run_op(1, 14, 0, 0);
    @(negedge clk); vld = 1'b0; rst_n = 1'b0; #2;
    chk(fl == 5'b0, "R14", fl, 0);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(TCK * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule